// File: doc/BRIEF.md
# Instruction Prefetch Scheduler

This block decides when to place instruction-word fetch requests on the bus for a three-word instruction pipeline. It stays idle until the sequencer issues a start request with a fetch address. From then on it runs by itself. It requests one word whenever the pipeline has a free slot, and it advances the fetch address by one 16-bit word each time the bus arbiter accepts a request.

Slots become free when an instruction completes or when an extension word is consumed. The scheduler never competes with operand traffic: while an operand access is pending, it holds back. It also holds back while the pipeline signals that the next instruction will redirect the stream, so no words are fetched only to be thrown away.

A taken change of flow is handled by a new start request. The start request does four things:
- it reloads the address;
- it marks every slot free;
- it withdraws any request still waiting;
- it flips a one-bit epoch tag.

Each request carries this tag. Returning data whose tag no longer matches is reported as stale, so words fetched before a flush are dropped.

Top module: `prefetch_sched`

## Requirements
- R1: Reset state. During and after reset, `pf_req`, `pf_addr` and `pf_tag` are 0. No request is raised before the first `start_req`, even if release strobes pulse.
- R2: `start_req` takes effect at the next clock edge. It loads `pf_addr` with `start_addr` and marks all 3 slots free. It drops `pf_req` to 0 in the following cycle, even if a request was waiting.
- R3: `pf_req` rises at the edge after a cycle in which all of these hold: the block has been started, no request is pending, `start_req` is low, at least one slot is free, `opnd_busy` is low and `cof_hint` is low.
- R4: Once raised, `pf_req` stays high and `pf_addr` stays unchanged until a cycle with `pf_ack` high, whatever `opnd_busy` and `cof_hint` do.
- R5: A cycle with `pf_req` and `pf_ack` both high consumes one slot and adds 2 to `pf_addr` at the next edge. It also makes `pf_req` low for at least the next cycle.
- R6: `insn_done` and `ext_used` each free one slot. Both high in one cycle free two. The free count saturates at 3, and a release affects issue decisions only from the following cycle.
- R7: With no free slot, no request is raised. After a start with no releases, exactly 3 fetches are made, at addresses start, start+2 and start+4.
- R8: `pf_tag` is 0 after reset and inverts at every `start_req`. `rd_accept` is high in the same cycle exactly when `rd_valid` is high and `rd_tag` equals `pf_tag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Start or redirect: load the address, flush the pipeline slots |
| start_addr | input | AW | Fetch address loaded by `start_req` |
| insn_done | input | 1 | An instruction completed; one slot freed |
| ext_used | input | 1 | An extension word was consumed; one slot freed |
| cof_hint | input | 1 | The next instruction will change the flow; hold fetches |
| opnd_busy | input | 1 | Operand accesses are outstanding; hold fetches |
| pf_req | output | 1 | Prefetch request to the bus arbiter |
| pf_addr | output | AW | Word address of the current or next fetch |
| pf_tag | output | 1 | Epoch tag that goes with the request |
| pf_ack | input | 1 | Arbiter accepts the pending request |
| rd_valid | input | 1 | Fetched word returning |
| rd_tag | input | 1 | Epoch tag of the returning word |
| rd_accept | output | 1 | Returning word belongs to the current stream |

## Verification
The results are due at three different times:
- `pf_req`, `pf_addr` and `pf_tag` are registered, so the effect of an input cycle shows one edge later.
- A slot freed in one cycle can raise a request only after a further edge.
- `rd_accept` follows its inputs within the same cycle.

The bench drives inputs on the falling edge and checks registered outputs on the next falling edge, one rising edge after the stimulus. It checks `rd_accept` a short delay after driving its inputs, before any rising edge. The vector table encodes the extra-cycle delay of releases directly in its expected columns.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int unsigned WORD_BYTES = 2;

  // number of slots freed by the two release strobes in one cycle
  function automatic logic [1:0] count_rel(input logic a, input logic b);
    return {1'b0, a} + {1'b0, b};
  endfunction
endpackage

// File: rtl/pfs_slot_ctr.sv
module pfs_slot_ctr #(
  parameter int DEPTH = 3,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_full,
  input  logic rel_a,
  input  logic rel_b,
  input  logic take,
  output logic has_room
);
  import pfs_pkg::*;

  logic [CW-1:0] slots;

  function automatic logic [CW-1:0] slot_next(input logic [CW-1:0] c,
                                               input logic [1:0] r,
                                               input logic t);
    int s;
    s = int'(c) + int'(r) - int'(t);
    if (s > DEPTH) s = DEPTH;
    if (s < 0) s = 0;
    return CW'(s);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)         slots <= '0;
    else if (load_full) slots <= CW'(DEPTH);
    else                slots <= slot_next(slots, count_rel(rel_a, rel_b), take);
  end

  assign has_room = (slots != '0);

  AST_SLOT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slots) <= DEPTH); // R6
  AST_SLOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (slots == '0) && !rel_a && !rel_b && !load_full |=> slots == '0); // R7
endmodule

// File: rtl/pfs_req_ctl.sv
module pfs_req_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic has_room,
  input  logic opnd_busy,
  input  logic cof_hint,
  input  logic pf_ack,
  output logic pf_req,
  output logic fire
);
  logic active;
  logic issue_ok;

  assign issue_ok = active && !pf_req && has_room && !opnd_busy && !cof_hint;
  assign fire     = pf_req && pf_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      pf_req <= 1'b0;
    end else begin
      if (start) active <= 1'b1;
      if (start)         pf_req <= 1'b0;
      else if (fire)     pf_req <= 1'b0;
      else if (issue_ok) pf_req <= 1'b1;
    end
  end

  AST_ISSUE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_req) |-> $past(active && has_room && !opnd_busy && !cof_hint)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req && !pf_ack && !start |=> pf_req); // R4
  AST_ACK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !pf_req); // R5
  AST_START_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !pf_req); // R2
endmodule

// File: rtl/pfs_addr_gen.sv
module pfs_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          fire,
  output logic [AW-1:0] addr
);
  import pfs_pkg::*;

  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return a + AW'(WORD_BYTES);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     addr <= '0;
    else if (start) addr <= start_addr;
    else if (fire)  addr <= addr_step(addr);
  end

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> addr == $past(start_addr)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start && !fire |=> $stable(addr)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !start && fire |=> addr == $past(addr) + AW'(2)); // R5
endmodule

// File: rtl/pfs_epoch.sv
module pfs_epoch (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rd_valid,
  input  logic rd_tag,
  output logic tag,
  output logic rd_accept
);
  always_ff @(posedge clk) begin
    if (!rst_n)     tag <= 1'b0;
    else if (start) tag <= ~tag;
  end

  assign rd_accept = rd_valid && (rd_tag == tag);

  AST_TAG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> tag != $past(tag)); // R8
  AST_TAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(tag)); // R8
endmodule

// File: rtl/prefetch_sched.sv
module prefetch_sched #(
  parameter int AW    = 16,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic [AW-1:0] start_addr,
  input  logic          insn_done,
  input  logic          ext_used,
  input  logic          cof_hint,
  input  logic          opnd_busy,
  output logic          pf_req,
  output logic [AW-1:0] pf_addr,
  output logic          pf_tag,
  input  logic          pf_ack,
  input  logic          rd_valid,
  input  logic          rd_tag,
  output logic          rd_accept
);
  logic has_room;
  logic fire;

  pfs_slot_ctr #(.DEPTH(DEPTH)) u_slots (
    .clk(clk), .rst_n(rst_n), .load_full(start_req),
    .rel_a(insn_done), .rel_b(ext_used), .take(fire), .has_room(has_room)
  );

  pfs_req_ctl u_req (
    .clk(clk), .rst_n(rst_n), .start(start_req), .has_room(has_room),
    .opnd_busy(opnd_busy), .cof_hint(cof_hint), .pf_ack(pf_ack),
    .pf_req(pf_req), .fire(fire)
  );

  pfs_addr_gen #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .start(start_req), .start_addr(start_addr),
    .fire(fire), .addr(pf_addr)
  );

  pfs_epoch u_epoch (
    .clk(clk), .rst_n(rst_n), .start(start_req), .rd_valid(rd_valid),
    .rd_tag(rd_tag), .tag(pf_tag), .rd_accept(rd_accept)
  );

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> !pf_req && pf_addr == '0 && !pf_tag); // R1
endmodule

// File: tb/prefetch_sched_test.sv
`timescale 1ns/100ps
module prefetch_sched_test;
  localparam int AW = 16;
  localparam int NV = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic insn_done = 1'b0, ext_used = 1'b0, cof_hint = 1'b0, opnd_busy = 1'b0;
  logic pf_req, pf_tag, rd_accept;
  logic [AW-1:0] pf_addr;
  logic pf_ack = 1'b0, rd_valid = 1'b0, rd_tag = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  prefetch_sched #(.AW(AW), .DEPTH(3)) uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_addr(start_addr),
    .insn_done(insn_done), .ext_used(ext_used), .cof_hint(cof_hint),
    .opnd_busy(opnd_busy), .pf_req(pf_req), .pf_addr(pf_addr), .pf_tag(pf_tag),
    .pf_ack(pf_ack), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_accept(rd_accept)
  );

  // [39] start [38:23] addr [22] done [21] ext [20] cof [19] busy [18] ack
  // [17] exp_req [16:1] exp_addr [0] exp_tag
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 16'h0100, 5'b00000, 1'b0, 16'h0100, 1'b1}, // R2 start
    {1'b0, 16'h0000, 5'b00000, 1'b1, 16'h0100, 1'b1}, // R3 issue
    {1'b0, 16'h0000, 5'b00001, 1'b0, 16'h0102, 1'b1}, // R5 ack
    {1'b0, 16'h0000, 5'b00010, 1'b0, 16'h0102, 1'b1}, // R3 busy blocks
    {1'b0, 16'h0000, 5'b00100, 1'b0, 16'h0102, 1'b1}, // R3 hint blocks
    {1'b0, 16'h0000, 5'b00000, 1'b1, 16'h0102, 1'b1}, // R3 issue
    {1'b0, 16'h0000, 5'b00010, 1'b1, 16'h0102, 1'b1}, // R4 hold under busy
    {1'b0, 16'h0000, 5'b00001, 1'b0, 16'h0104, 1'b1}, // R5 one slot left
    {1'b0, 16'h0000, 5'b00000, 1'b1, 16'h0104, 1'b1},
    {1'b0, 16'h0000, 5'b00001, 1'b0, 16'h0106, 1'b1}, // R7 slots empty
    {1'b0, 16'h0000, 5'b00000, 1'b0, 16'h0106, 1'b1}, // R7 no issue
    {1'b0, 16'h0000, 5'b01000, 1'b0, 16'h0106, 1'b1}, // R6 release seen later
    {1'b0, 16'h0000, 5'b00000, 1'b1, 16'h0106, 1'b1}, // R6 issue after release
    {1'b0, 16'h0000, 5'b11001, 1'b0, 16'h0108, 1'b1}, // R6 double release + ack
    {1'b0, 16'h0000, 5'b00000, 1'b1, 16'h0108, 1'b1},
    {1'b0, 16'h0000, 5'b00001, 1'b0, 16'h010A, 1'b1},
    {1'b0, 16'h0000, 5'b11000, 1'b1, 16'h010A, 1'b1}, // R6 saturate at 3
    {1'b0, 16'h0000, 5'b00001, 1'b0, 16'h010C, 1'b1},
    {1'b0, 16'h0000, 5'b11000, 1'b1, 16'h010C, 1'b1},
    {1'b1, 16'h0200, 5'b00000, 1'b0, 16'h0200, 1'b0}  // R2 start drops pending
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [AW-1:0] a, input logic d,
                       input logic e, input logic c, input logic b, input logic k);
    start_req = s; start_addr = a; insn_done = d; ext_used = e;
    cof_hint = c; opnd_busy = b; pf_ack = k;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int nfetch;
    int consec;
    logic [AW-1:0] first_a;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 req in reset", 32'(pf_req), 32'd0);
    chk("R1 addr in reset", 32'(pf_addr), 32'd0);
    chk("R1 tag in reset", 32'(pf_tag), 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      drive(1'b0, '0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      chk("R1 no request before start", 32'(pf_req), 32'd0);
    end
    drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][39], VEC[v][38:23], VEC[v][22], VEC[v][21], VEC[v][20],
            VEC[v][19], VEC[v][18]);
      @(negedge clk);
      chk($sformatf("R2-R7 vec%0d req", v), 32'(pf_req), 32'(VEC[v][17]));
      chk($sformatf("R4/R5 vec%0d addr", v), 32'(pf_addr), 32'(VEC[v][16:1]));
      chk($sformatf("R8 vec%0d tag", v), 32'(pf_tag), 32'(VEC[v][0]));
    end

    // R7: from full, with ack held, exactly three fetches and no back-to-back requests (R5)
    drive(1'b1, 16'h0300, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    nfetch = 0;
    consec = 0;
    first_a = '1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pf_req) begin
        if (nfetch == 0) first_a = pf_addr;
        nfetch++;
        consec++;
        if (consec > 1) chk("R5 gap after ack", 32'(consec), 32'd1);
      end else consec = 0;
    end
    chk("R7 fetch count from full", 32'(nfetch), 32'd3);
    chk("R7 first fetch address", 32'(first_a), 32'h0300);
    chk("R7 final address", 32'(pf_addr), 32'h0306);
    drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R8 stale filter; tag is now 1
    chk("R8 tag after third start", 32'(pf_tag), 32'd1);
    rd_valid = 1'b1; rd_tag = 1'b1; #1;
    chk("R8 current tag accepted", 32'(rd_accept), 32'd1);
    rd_tag = 1'b0; #1;
    chk("R8 old tag dropped", 32'(rd_accept), 32'd0);
    rd_valid = 1'b0; rd_tag = 1'b1; #1;
    chk("R8 no valid no accept", 32'(rd_accept), 32'd0);
    @(negedge clk);
    drive(1'b1, 16'h0400, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 tag flips on start", 32'(pf_tag), 32'd0);
    chk("R2 address reload", 32'(pf_addr), 32'h0400);
    rd_valid = 1'b1; rd_tag = 1'b1; #1;
    chk("R8 pre-flush word dropped", 32'(rd_accept), 32'd0);
    rd_valid = 1'b0;

    // R4: hint and busy while pending do not withdraw the request
    @(negedge clk);
    chk("R3 issue after reload", 32'(pf_req), 32'd1);
    drive(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    chk("R4 hold under hint", 32'(pf_req), 32'd1);
    chk("R4 address stable", 32'(pf_addr), 32'h0400);
    drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule